// File: doc/BRIEF.md
# Virtualization Enable Permission Controller

This block decides, for each processor, whether a request to enter or leave virtualization mode may go ahead. It holds a small feature-control register that firmware programs once and then locks. It also tracks whether the processor is currently in secure mode and whether virtualization mode is active.

Every enter or leave request gets a registered fault code one clock later: none, invalid-opcode, or general-protection. Writes to the feature-control register are checked in the same way. A write can fault because the register is locked, because it sets a reserved bit, or because it enables a mode that the capability straps do not allow.

The caller supplies the virtualization-enable control bit and the low offset bits of the region pointer with each enter request. Instruction decode, memory access to the region and control-register fixed-bit rules are handled elsewhere.

Top module: `vperm_ctrl`

## Requirements
- R1: Synchronous active-high reset clears the feature-control register to zero, clears the mode flag, makes secure mode inactive and sets the fault code to 2'b00 (none).
- R2: A register write (cfg_sel and cfg_we high) that raises no fault stores wdata bits [2:0]. Bit 0 is the lock, bit 1 the secure-mode entry enable and bit 2 the open-mode entry enable. The new value shows on cfg_rdata after that clock edge, with bits above 2 reading zero, and the fault code is none.
- R3: While the lock bit is 1, every register write gives fault code 2'b10 (general-protection) and the contents do not change until reset.
- R4: A write that sets a reserved bit (bit 3 or above), or sets bit 1 without both capability straps, or sets bit 2 without the virtualization capability strap gives 2'b10 and leaves the register unchanged.
- R5: An enter request with virt_en_ctl low gives fault code 2'b01 (invalid-opcode), whatever else holds. This check has the highest priority.
- R6: An enter request with virt_en_ctl high and the lock bit clear gives 2'b10.
- R7: An enter request that passes R5 and R6 selects enable bit 1 if secure mode is active and bit 2 otherwise. If the selected bit is clear, the result is 2'b10.
- R8: An enter request that passes R5 to R7 but has any of the low ALIGN_BITS pointer bits set gives 2'b10.
- R9: An enter request that passes R5 to R8 gives fault code none and sets the mode flag.
- R10: A leave request while the mode flag is set gives none and clears the flag. A leave request while the flag is clear gives 2'b01.
- R11: A secure-enter pulse makes secure mode active. A secure-exit pulse makes it inactive. An exit pulse while inactive has no effect. The new state governs requests from the next cycle.
- R12: The fault code is registered and lasts one cycle. After a cycle with no request and no write, it is none, and it never takes the value 2'b11.
- R13: In a cycle with both a request and a write, the request's result is reported. When enter and leave are both asserted, only the enter is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 1 | Write address matches the feature-control register |
| cfg_we | input | 1 | Write strobe |
| cfg_wdata | input | CFG_W | Write data |
| cap_virt | input | 1 | Virtualization capability strap |
| cap_secure | input | 1 | Secure-mode capability strap |
| sec_enter | input | 1 | Secure-mode entry event pulse |
| sec_exit | input | 1 | Secure-mode exit event pulse |
| virt_en_ctl | input | 1 | Virtualization-enable control bit |
| req_ptr_lo | input | ALIGN_BITS | Low offset bits of the region pointer |
| req_enter | input | 1 | Enter-virtualization request pulse |
| req_leave | input | 1 | Leave-virtualization request pulse |
| fault_code | output | 2 | 00 none, 01 invalid-opcode, 10 general-protection |
| virt_active | output | 1 | Virtualization mode flag |
| cfg_rdata | output | CFG_W | Feature-control register readback |

## Verification
The fault code and mode flag for a request or write presented in one cycle are due right after the next rising edge. The register readback changes at that same edge. A secure-mode pulse changes only how requests in later cycles are judged.

The driver stamps each expected item with the cycle in which it is due. The monitor compares at the falling edge of exactly that cycle, so a wrong code, a stale flag or a one-cycle slip is caught. Capability strap cases are run after separate resets, because the lock survives everything except reset.

// File: rtl/vperm_pkg.sv
`timescale 1ns/1ps
package vperm_pkg;

    typedef enum logic [1:0] {
        FC_NONE  = 2'b00,
        FC_UDEF  = 2'b01,
        FC_GPROT = 2'b10
    } fault_e;

    localparam int CTL_BITS = 3;

    typedef struct packed {
        logic en_open;
        logic en_sec;
        logic lock;
    } fctl_t;

    function automatic fault_e merge_fault(input logic req_any, input fault_e rq, input fault_e wr);
        return req_any ? rq : wr;
    endfunction

endpackage

// File: rtl/vperm_fcreg.sv
`timescale 1ns/1ps
module vperm_fcreg
    import vperm_pkg::*;
#(
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    input  logic             cap_virt,
    input  logic             cap_sec,
    output fctl_t            q,
    output fault_e           wr_fault,
    output logic [CFG_W-1:0] rdata
);
    localparam int RSV_W = CFG_W - CTL_BITS;

    logic  wr_hit;
    logic  rsv_set;
    logic  lack_sec;
    logic  lack_virt;
    logic  refuse;
    fctl_t req_val;

    assign wr_hit    = sel & we;
    assign req_val   = fctl_t'(wdata[CTL_BITS-1:0]);
    assign rsv_set   = |wdata[CFG_W-1:CTL_BITS];
    assign lack_sec  = req_val.en_sec & ~(cap_virt & cap_sec);
    assign lack_virt = req_val.en_open & ~cap_virt;
    assign refuse    = q.lock | rsv_set | lack_sec | lack_virt;

    always_comb begin
        if (!wr_hit)
            wr_fault = FC_NONE;
        else if (refuse)
            wr_fault = FC_GPROT;
        else
            wr_fault = FC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (wr_hit && !refuse)
            q <= req_val;
    end

    assign rdata = {{RSV_W{1'b0}}, q};

endmodule

// File: rtl/vperm_secmode.sv
`timescale 1ns/1ps
module vperm_secmode (
    input  logic clk,
    input  logic rst,
    input  logic enter,
    input  logic leave,
    output logic in_sec
);
    always_ff @(posedge clk) begin
        if (rst)
            in_sec <= 1'b0;
        else if (enter)
            in_sec <= 1'b1;
        else if (leave)
            in_sec <= 1'b0;
    end
endmodule

// File: rtl/vperm_gate.sv
`timescale 1ns/1ps
module vperm_gate
    import vperm_pkg::*;
#(
    parameter int ALIGN_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enter,
    input  logic                  leave,
    input  logic                  ctl_en,
    input  logic [ALIGN_BITS-1:0] ptr_lo,
    input  fctl_t                 cfg,
    input  logic                  in_sec,
    output fault_e                req_fault,
    output logic                  req_any,
    output logic                  active
);
    logic   mode_ok;
    logic   misalign;
    fault_e enter_fault;
    fault_e leave_fault;

    assign mode_ok  = in_sec ? cfg.en_sec : cfg.en_open;
    assign misalign = |ptr_lo;
    assign req_any  = enter | leave;

    always_comb begin
        if (!ctl_en)
            enter_fault = FC_UDEF;
        else if (!cfg.lock)
            enter_fault = FC_GPROT;
        else if (!mode_ok)
            enter_fault = FC_GPROT;
        else if (misalign)
            enter_fault = FC_GPROT;
        else
            enter_fault = FC_NONE;
    end

    assign leave_fault = active ? FC_NONE : FC_UDEF;

    always_comb begin
        if (enter)
            req_fault = enter_fault;
        else if (leave)
            req_fault = leave_fault;
        else
            req_fault = FC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else if (enter) begin
            if (enter_fault == FC_NONE)
                active <= 1'b1;
        end else if (leave)
            active <= 1'b0;
    end
endmodule

// File: rtl/vperm_ctrl.sv
`timescale 1ns/1ps
module vperm_ctrl
    import vperm_pkg::*;
#(
    parameter int CFG_W      = 32,
    parameter int ALIGN_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_sel,
    input  logic                  cfg_we,
    input  logic [CFG_W-1:0]      cfg_wdata,
    input  logic                  cap_virt,
    input  logic                  cap_secure,
    input  logic                  sec_enter,
    input  logic                  sec_exit,
    input  logic                  virt_en_ctl,
    input  logic [ALIGN_BITS-1:0] req_ptr_lo,
    input  logic                  req_enter,
    input  logic                  req_leave,
    output logic [1:0]            fault_code,
    output logic                  virt_active,
    output logic [CFG_W-1:0]      cfg_rdata
);
    fctl_t  cfg_q;
    fault_e wr_fault;
    fault_e req_fault;
    logic   req_any;
    logic   in_sec;
    fault_e fault_q;

    vperm_fcreg #(.CFG_W(CFG_W)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .sel      (cfg_sel),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .cap_virt (cap_virt),
        .cap_sec  (cap_secure),
        .q        (cfg_q),
        .wr_fault (wr_fault),
        .rdata    (cfg_rdata)
    );

    vperm_secmode u_sec (
        .clk    (clk),
        .rst    (rst),
        .enter  (sec_enter),
        .leave  (sec_exit),
        .in_sec (in_sec)
    );

    vperm_gate #(.ALIGN_BITS(ALIGN_BITS)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .enter     (req_enter),
        .leave     (req_leave),
        .ctl_en    (virt_en_ctl),
        .ptr_lo    (req_ptr_lo),
        .cfg       (cfg_q),
        .in_sec    (in_sec),
        .req_fault (req_fault),
        .req_any   (req_any),
        .active    (virt_active)
    );

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= FC_NONE;
        else
            fault_q <= merge_fault(req_any, req_fault, wr_fault);
    end

    assign fault_code = fault_q;

endmodule

// File: rtl/vperm_chk.sv
`timescale 1ns/1ps
module vperm_chk #(
    parameter int CFG_W      = 32,
    parameter int ALIGN_BITS = 12
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cfg_sel,
    input logic                  cfg_we,
    input logic                  virt_en_ctl,
    input logic [ALIGN_BITS-1:0] req_ptr_lo,
    input logic                  req_enter,
    input logic                  req_leave,
    input logic [1:0]            fault_code,
    input logic                  virt_active,
    input logic [CFG_W-1:0]      cfg_rdata
);
    AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[0] |=> $stable(cfg_rdata)); // R3

    AST_LOCKED_WRITE_GP: assert property (@(posedge clk) disable iff (rst)
        (cfg_sel && cfg_we && cfg_rdata[0] && !req_enter && !req_leave) |=> (fault_code == 2'b10)); // R3

    AST_NO_CTL_UDEF: assert property (@(posedge clk) disable iff (rst)
        (req_enter && !virt_en_ctl) |=> (fault_code == 2'b01)); // R5

    AST_UNLOCKED_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (req_enter && !cfg_rdata[0] && !virt_active) |=> !virt_active); // R6

    AST_MISALIGN_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (req_enter && !virt_active && (|req_ptr_lo)) |=> !virt_active); // R8

    AST_ENTRY_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $rose(virt_active) |-> (fault_code == 2'b00)); // R9

    AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (req_leave && !req_enter) |=> !virt_active); // R10

    AST_LEAVE_IDLE_UDEF: assert property (@(posedge clk) disable iff (rst)
        (req_leave && !req_enter && !virt_active) |=> (fault_code == 2'b01)); // R10

    AST_IDLE_NONE: assert property (@(posedge clk) disable iff (rst)
        (!req_enter && !req_leave && !(cfg_sel && cfg_we)) |=> (fault_code == 2'b00)); // R12

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        fault_code != 2'b11); // R12

endmodule

bind vperm_ctrl vperm_chk #(.CFG_W(CFG_W), .ALIGN_BITS(ALIGN_BITS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_sel     (cfg_sel),
    .cfg_we      (cfg_we),
    .virt_en_ctl (virt_en_ctl),
    .req_ptr_lo  (req_ptr_lo),
    .req_enter   (req_enter),
    .req_leave   (req_leave),
    .fault_code  (fault_code),
    .virt_active (virt_active),
    .cfg_rdata   (cfg_rdata)
);

// File: tb/sim_vperm_ctrl.sv
`timescale 1ns/1ps
module sim_vperm_ctrl;
    localparam int CFG_W      = 32;
    localparam int ALIGN_BITS = 12;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic                  cfg_sel = 1'b0;
    logic                  cfg_we = 1'b0;
    logic [CFG_W-1:0]      cfg_wdata = '0;
    logic                  cap_virt = 1'b1;
    logic                  cap_secure = 1'b1;
    logic                  sec_enter = 1'b0;
    logic                  sec_exit = 1'b0;
    logic                  virt_en_ctl = 1'b0;
    logic [ALIGN_BITS-1:0] req_ptr_lo = '0;
    logic                  req_enter = 1'b0;
    logic                  req_leave = 1'b0;
    logic [1:0]            fault_code;
    logic                  virt_active;
    logic [CFG_W-1:0]      cfg_rdata;

    always #2.5 clk = ~clk;

    vperm_ctrl #(.CFG_W(CFG_W), .ALIGN_BITS(ALIGN_BITS)) u0 (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cap_virt(cap_virt), .cap_secure(cap_secure), .sec_enter(sec_enter), .sec_exit(sec_exit),
        .virt_en_ctl(virt_en_ctl), .req_ptr_lo(req_ptr_lo), .req_enter(req_enter),
        .req_leave(req_leave), .fault_code(fault_code), .virt_active(virt_active),
        .cfg_rdata(cfg_rdata)
    );

    typedef struct {
        int               due;
        logic [1:0]       fc;
        logic             act;
        logic [CFG_W-1:0] rd;
        string            tag;
    } exp_t;

    exp_t sbq[$];
    exp_t mon_e;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;

    logic [2:0] m_reg = 3'b000;
    logic       m_sec = 1'b0;
    logic       m_act = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops each expected item in the cycle it is due
    always @(negedge clk) begin
        if (sbq.size() > 0 && sbq[0].due == cyc) begin
            mon_e = sbq.pop_front();
            n_chk++;
            if (fault_code !== mon_e.fc || virt_active !== mon_e.act || cfg_rdata !== mon_e.rd) begin
                n_err++;
                $display("FAIL %s: fc=%0d act=%0b rd=%h expected fc=%0d act=%0b rd=%h",
                         mon_e.tag, fault_code, virt_active, cfg_rdata, mon_e.fc, mon_e.act, mon_e.rd);
            end
        end
    end

    function automatic logic [1:0] wr_model(input logic [CFG_W-1:0] d);
        if (m_reg[0] || (|d[CFG_W-1:3]) || (d[1] && !(cap_virt && cap_secure)) || (d[2] && !cap_virt))
            return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [1:0] enter_model(input logic ctl, input logic [ALIGN_BITS-1:0] p);
        if (!ctl) return 2'b01;
        if (!m_reg[0]) return 2'b10;
        if (!(m_sec ? m_reg[1] : m_reg[2])) return 2'b10;
        if (|p) return 2'b10;
        return 2'b00;
    endfunction

    // driver: one stimulus cycle, expected item pushed to the scoreboard
    task automatic step(input logic w, input logic [CFG_W-1:0] d, input logic en, input logic lv,
                        input logic ctl, input logic [ALIGN_BITS-1:0] p,
                        input logic se, input logic sx, input string tag);
        logic [1:0] fw;
        logic [1:0] fe;
        logic [1:0] fc;
        exp_t e;
        @(negedge clk);
        cfg_sel = w; cfg_we = w; cfg_wdata = d;
        req_enter = en; req_leave = lv; virt_en_ctl = ctl; req_ptr_lo = p;
        sec_enter = se; sec_exit = sx;
        fw = w ? wr_model(d) : 2'b00;
        fe = enter_model(ctl, p);
        if (en) fc = fe;
        else if (lv) fc = m_act ? 2'b00 : 2'b01;
        else fc = fw;
        if (en) begin
            if (fe == 2'b00) m_act = 1'b1;
        end else if (lv) m_act = 1'b0;
        if (w && fw == 2'b00) m_reg = d[2:0];
        if (se) m_sec = 1'b1;
        else if (sx) m_sec = 1'b0;
        e.due = cyc + 1; e.fc = fc; e.act = m_act; e.rd = {{(CFG_W-3){1'b0}}, m_reg}; e.tag = tag;
        sbq.push_back(e);
        @(posedge clk);
        #1;
        cfg_sel = 0; cfg_we = 0; cfg_wdata = '0; req_enter = 0; req_leave = 0;
        virt_en_ctl = 0; req_ptr_lo = '0; sec_enter = 0; sec_exit = 0;
    endtask

    task automatic wr(input logic [CFG_W-1:0] d, input string tag);
        step(1, d, 0, 0, 0, '0, 0, 0, tag);
    endtask
    task automatic ent(input logic [ALIGN_BITS-1:0] p, input logic ctl, input string tag);
        step(0, '0, 1, 0, ctl, p, 0, 0, tag);
    endtask
    task automatic lve(input string tag);
        step(0, '0, 0, 1, 0, '0, 0, 0, tag);
    endtask
    task automatic sec(input logic se, input logic sx, input string tag);
        step(0, '0, 0, 0, 0, '0, se, sx, tag);
    endtask
    task automatic idle(input string tag);
        step(0, '0, 0, 0, 0, '0, 0, 0, tag);
    endtask

    task automatic do_reset(input logic cv, input logic cs);
        repeat (3) @(negedge clk);
        rst = 1; cap_virt = cv; cap_secure = cs;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_reg = 3'b000; m_sec = 1'b0; m_act = 1'b0;
        idle("R1 reset state");
    endtask

    initial begin
        do_reset(1, 1);
        ent(12'h000, 0, "R5 ctl bit low");
        ent(12'h000, 1, "R6 lock clear");
        lve("R10 leave while inactive");
        wr(32'h0000_0010, "R4 reserved bit");
        wr(32'h0000_0002, "R2 write sec enable");
        wr(32'h0000_0006, "R2 write both enables");
        wr(32'h0000_0005, "R2 write lock");
        wr(32'h0000_0004, "R3 locked write");
        idle("R12 one-cycle fault");
        ent(12'h001, 1, "R8 misaligned pointer");
        ent(12'h800, 1, "R8 misaligned top bit");
        sec(1, 0, "R11 secure enter");
        ent(12'h000, 1, "R7 secure bit clear");
        sec(0, 1, "R11 secure exit");
        ent(12'h000, 1, "R9 enter ok");
        idle("R12 idle keeps mode");
        ent(12'h000, 0, "R5 ctl low while active");
        lve("R10 leave active");
        sec(0, 1, "R11 exit without enter");
        ent(12'h000, 1, "R11 still outside secure");
        lve("R10 leave again");
        step(1, 32'h0000_0007, 1, 0, 0, '0, 0, 0, "R13 request over write");
        step(0, '0, 1, 1, 1, '0, 0, 0, "R13 enter over leave");
        lve("R10 leave after both");

        do_reset(1, 0);
        wr(32'h0000_0002, "R4 sec enable without secure cap");
        wr(32'h0000_0004, "R2 open enable allowed");

        do_reset(0, 1);
        wr(32'h0000_0004, "R4 open enable without virt cap");
        wr(32'h0000_0002, "R4 sec enable without virt cap");
        wr(32'h0000_0001, "R2 lock only");
        ent(12'h000, 1, "R7 open bit clear");

        do_reset(1, 1);
        wr(32'h0000_0003, "R2 lock with sec enable");
        ent(12'h000, 1, "R7 outside secure uses bit 2");
        sec(1, 0, "R11 secure enter again");
        ent(12'h000, 1, "R7 secure entry ok");

        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL R12: %0d results never appeared, expected 0", sbq.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule